// File: doc/BRIEF.md
# Latched Rail Enable Decoder

This block turns the current operating state of a board power controller into the on/off enables of the switched supply planes. It handles the 3.3 V dual plane, the 5 V dual plane, the memory plane and the clock-chip supply. The 3.3 V and 5 V dual planes share one main-supply switch enable for active operation, and each has its own standby-path enable for sleep. The memory plane has two active-path enables, a regulated driver for the 2.5 V setting and a fully-on switch for the 3.3 V setting, plus a standby-path enable. The clock-chip supply has a single enable.

Two configuration straps decide which dual planes stay powered while asleep. The straps are not read continuously. They are captured only when power-on reset is released, when shutdown ends, and when the block leaves active operation for a sleep state. Strap changes made while asleep therefore do nothing. The memory-voltage select is a separate latch loaded from a comparator on a ramp-done strobe. A sequencer with four phases applies each change of operating state through a one-cycle all-off gap. The phases are POR wait, halt, gap and live, and the applied mode is one of run, suspend-to-RAM or soft-off.

Top module: `rail_enable_decoder`

## Requirements
- R1: After reset every enable output is 0, and it stays 0 until a power-on-release strobe `por_rel_p` is sampled with `shutdown` low. That strobe captures the straps, gives one all-off gap cycle, and then applies the requested mode.
- R2: The straps are captured only on a power-on release, on shutdown release, and on a move from run mode to a sleep mode. A strap change made at any other time, in particular while asleep, leaves every enable unchanged.
- R3: `op_req` uses these codes: 2'b00 is run, 2'b01 is suspend-to-RAM, 2'b10 is soft-off and 2'b11 is no request. In run, `main_sw_en` is 1 and every standby enable is 0. `d3_sby_en` is 1 in suspend-to-RAM. In soft-off it is 1 only when the captured `strap_raw[0]` is 0.
- R4: `d5_sby_en` is 1 in suspend-to-RAM and soft-off only when the captured `strap_raw[1]` is 1. It is 0 in run.
- R5: In run, the memory plane uses `mem_lin_en` when the select is 0 (2.5 V) and `mem_sw_en` when the select is 1 (3.3 V). `mem_sby_en` is 1 only in suspend-to-RAM. All three memory enables are 0 in soft-off, and at most one of them is 1 at any time.
- R6: `clk_rail_en` is 1 only while run mode is applied.
- R7: `mem_sel_hi` resets to 0 and loads `msel_cmp` in each cycle where `msel_latch_p` is 1. At all other times it holds, whatever the comparator does.
- R8: Every change of applied mode passes through exactly one cycle with all enables 0. The active and standby enables of one plane are never 1 together.
- R9: A request to move directly between suspend-to-RAM and soft-off is ignored, and so is code 2'b11. The applied mode holds.
- R10: One cycle after `shutdown` is sampled high, every enable is 0. On release the straps are recaptured, one gap cycle follows, and then the current request is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_req | input | 2 | Requested operating state (00 run, 01 suspend-to-RAM, 10 soft-off, 11 none) |
| strap_raw | input | 2 | Raw straps: bit 0 = 3.3 V dual off in soft-off, bit 1 = 5 V dual kept in sleep |
| msel_cmp | input | 1 | Memory-voltage comparator result (1 = 3.3 V) |
| msel_latch_p | input | 1 | Ramp-done strobe that loads the memory select |
| por_rel_p | input | 1 | Power-on reset release strobe |
| shutdown | input | 1 | Forces all enables off while high |
| main_sw_en | output | 1 | Shared main-supply switch for both dual planes |
| d3_sby_en | output | 1 | 3.3 V dual standby-path enable |
| d5_sby_en | output | 1 | 5 V dual standby-path enable |
| mem_lin_en | output | 1 | Memory regulated active driver (2.5 V setting) |
| mem_sw_en | output | 1 | Memory fully-on active switch (3.3 V setting) |
| mem_sby_en | output | 1 | Memory standby-path enable |
| clk_rail_en | output | 1 | Clock-chip supply enable |
| mem_sel_hi | output | 1 | Latched memory-voltage select |

## Verification
Every input is sampled by one register stage, and all outputs decode registers only. A request, strobe or shutdown therefore shows at the outputs one clock after the edge that samples it. A mode change shows the all-off gap in that first cycle and the new pattern one clock later. The bench applies stimulus just after a falling edge and keeps a behavioural model that advances on each rising edge. It compares all eight outputs against that model at every falling edge, so each result is checked in exactly the cycle it is due. Directed checks read the ports at those same points after strap toggles, illegal requests and shutdown.

// File: rtl/rde_pkg.sv
package rde_pkg;

    localparam int STRAP_W  = 2;
    localparam int STRAP_3V = 0;   // 1: 3.3 V dual plane dropped in soft-off
    localparam int STRAP_5V = 1;   // 1: 5 V dual plane kept through sleep

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_STR  = 2'b01,
        MODE_OFF  = 2'b10,
        MODE_NONE = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        PH_PORWAIT = 2'b00,
        PH_HALT    = 2'b01,
        PH_GAP     = 2'b10,
        PH_LIVE    = 2'b11
    } phase_e;

    typedef struct packed {
        logic main_sw;
        logic d3_sby;
        logic d5_sby;
        logic mem_lin;
        logic mem_sw;
        logic mem_sby;
        logic clk_rail;
    } rail_en_t;

endpackage

// File: rtl/rde_seq.sv
module rde_seq
    import rde_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_i,
    input  logic       por_rel_i,
    input  logic       shutdown_i,
    output phase_e     phase_o,
    output mode_e      mode_o,
    output logic       cap_o
);

    phase_e ph_q, ph_d;
    mode_e  md_q, md_d;
    mode_e  req_m;

    assign req_m = mode_e'(req_i);

    function automatic logic hop_ok(input mode_e from_m, input mode_e to_m);
        return (to_m != MODE_NONE) && (to_m != from_m) &&
               ((from_m == MODE_RUN) || (to_m == MODE_RUN));
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_PORWAIT;
            md_q <= MODE_RUN;
        end else begin
            ph_q <= ph_d;
            md_q <= md_d;
        end
    end

    always_comb begin
        ph_d  = ph_q;
        md_d  = md_q;
        cap_o = 1'b0;
        unique case (ph_q)
            PH_PORWAIT: begin
                if (!shutdown_i && por_rel_i) begin
                    cap_o = 1'b1;
                    ph_d  = PH_GAP;
                    if (req_m != MODE_NONE) md_d = req_m;
                end
            end
            PH_HALT: begin
                if (!shutdown_i) begin
                    cap_o = 1'b1;
                    ph_d  = PH_GAP;
                    if (req_m != MODE_NONE) md_d = req_m;
                end
            end
            PH_GAP: begin
                ph_d = shutdown_i ? PH_HALT : PH_LIVE;
            end
            PH_LIVE: begin
                if (shutdown_i) begin
                    ph_d = PH_HALT;
                end else if (hop_ok(md_q, req_m)) begin
                    ph_d  = PH_GAP;
                    md_d  = req_m;
                    cap_o = (md_q == MODE_RUN);
                end
            end
        endcase
    end

    assign phase_o = ph_q;
    assign mode_o  = md_q;

    // R10: shutdown reaches an all-off phase one cycle later
    assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_i |=> (ph_q == PH_HALT || ph_q == PH_PORWAIT));

    // R9: leaving a sleep mode can only lead to run
    assert_legal_hop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_GAP && $past(ph_q) == PH_LIVE && $past(md_q) != MODE_RUN)
        |-> md_q == MODE_RUN);

    // R8: the handover gap lasts a single cycle
    assert_gap_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_GAP |=> ph_q != PH_GAP);

endmodule

// File: rtl/rde_latch.sv
module rde_latch #(
    parameter int             W          = 2,
    parameter logic [W-1:0]   STRAP_INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic [W-1:0] raw_i,
    input  logic         sel_p_i,
    input  logic         cmp_i,
    output logic [W-1:0] strap_o,
    output logic         sel_o
);

    logic [W-1:0] strap_q;
    logic         sel_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     strap_q[b] <= STRAP_INIT[b];
            else if (cap_i) strap_q[b] <= raw_i[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sel_q <= 1'b0;
        else if (sel_p_i) sel_q <= cmp_i;
    end

    assign strap_o = strap_q;
    assign sel_o   = sel_q;

    // R2: captured straps move only on a capture event
    assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(strap_q));

    // R7: select holds without its strobe
    assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_p_i |=> $stable(sel_q));

endmodule

// File: rtl/rde_decode.sv
module rde_decode
    import rde_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  phase_e             phase_i,
    input  mode_e              mode_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               sel_i,
    output rail_en_t           en_o
);

    always_comb begin
        en_o = '0;
        if (phase_i == PH_LIVE) begin
            unique case (mode_i)
                MODE_RUN: begin
                    en_o.main_sw  = 1'b1;
                    en_o.clk_rail = 1'b1;
                    en_o.mem_lin  = !sel_i;
                    en_o.mem_sw   = sel_i;
                end
                MODE_STR: begin
                    en_o.d3_sby  = 1'b1;
                    en_o.d5_sby  = strap_i[STRAP_5V];
                    en_o.mem_sby = 1'b1;
                end
                MODE_OFF: begin
                    en_o.d3_sby = !strap_i[STRAP_3V];
                    en_o.d5_sby = strap_i[STRAP_5V];
                end
                MODE_NONE: begin
                    en_o = '0;
                end
            endcase
        end
    end

    // R8: a plane never has both paths on
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_o.main_sw && (en_o.d3_sby || en_o.d5_sby)));

    // R8: the main switch turns on only after a cycle with standby paths off
    assert_gap_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o.main_sw) |-> $past(!(en_o.d3_sby || en_o.d5_sby || en_o.mem_sby)));

    // R8: a standby path never starts in the cycle right after active operation
    assert_gap_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_o.main_sw) |-> !(en_o.d3_sby || en_o.d5_sby || en_o.mem_sby));

    // R5: memory paths are mutually exclusive
    assert_mem_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_o.mem_lin, en_o.mem_sw, en_o.mem_sby}));

    // R6: clock rail lives only with active operation
    assert_clk_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_o.clk_rail |-> (en_o.main_sw && !en_o.mem_sby));

endmodule

// File: rtl/rail_enable_decoder.sv
module rail_enable_decoder
    import rde_pkg::*;
#(
    parameter logic [STRAP_W-1:0] STRAP_INIT = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] op_req,
    input  logic [1:0] strap_raw,
    input  logic       msel_cmp,
    input  logic       msel_latch_p,
    input  logic       por_rel_p,
    input  logic       shutdown,
    output logic       main_sw_en,
    output logic       d3_sby_en,
    output logic       d5_sby_en,
    output logic       mem_lin_en,
    output logic       mem_sw_en,
    output logic       mem_sby_en,
    output logic       clk_rail_en,
    output logic       mem_sel_hi
);

    phase_e             phase;
    mode_e              mode;
    logic               cap;
    logic [STRAP_W-1:0] strap_q;
    logic               sel_q;
    rail_en_t           en;

    rde_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (op_req),
        .por_rel_i  (por_rel_p),
        .shutdown_i (shutdown),
        .phase_o    (phase),
        .mode_o     (mode),
        .cap_o      (cap)
    );

    rde_latch #(
        .W          (STRAP_W),
        .STRAP_INIT (STRAP_INIT)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap),
        .raw_i   (strap_raw),
        .sel_p_i (msel_latch_p),
        .cmp_i   (msel_cmp),
        .strap_o (strap_q),
        .sel_o   (sel_q)
    );

    rde_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .mode_i  (mode),
        .strap_i (strap_q),
        .sel_i   (sel_q),
        .en_o    (en)
    );

    assign main_sw_en  = en.main_sw;
    assign d3_sby_en   = en.d3_sby;
    assign d5_sby_en   = en.d5_sby;
    assign mem_lin_en  = en.mem_lin;
    assign mem_sw_en   = en.mem_sw;
    assign mem_sby_en  = en.mem_sby;
    assign clk_rail_en = en.clk_rail;
    assign mem_sel_hi  = sel_q;

endmodule

// File: tb/tb_rail_enable_decoder.sv
module tb_rail_enable_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_req = 2'b00;
    logic [1:0] strap_raw = 2'b00;
    logic       msel_cmp = 1'b0;
    logic       msel_latch_p = 1'b0;
    logic       por_rel_p = 1'b0;
    logic       shutdown = 1'b0;
    logic main_sw_en, d3_sby_en, d5_sby_en, mem_lin_en, mem_sw_en, mem_sby_en, clk_rail_en, mem_sel_hi;

    int compared = 0;
    int mism = 0;

    always #2 clk = ~clk;

    rail_enable_decoder dut (
        .clk(clk), .rst_n(rst_n), .op_req(op_req), .strap_raw(strap_raw),
        .msel_cmp(msel_cmp), .msel_latch_p(msel_latch_p), .por_rel_p(por_rel_p),
        .shutdown(shutdown), .main_sw_en(main_sw_en), .d3_sby_en(d3_sby_en),
        .d5_sby_en(d5_sby_en), .mem_lin_en(mem_lin_en), .mem_sw_en(mem_sw_en),
        .mem_sby_en(mem_sby_en), .clk_rail_en(clk_rail_en), .mem_sel_hi(mem_sel_hi)
    );

    // behavioural model: phase 0 wait-por, 1 halted, 2 gap, 3 live; mode 0 run, 1 STR, 2 off
    int ph = 0, md = 0, st3 = 0, st5 = 0, sel = 0;

    always @(posedge clk) begin
        int rq;
        rq = op_req;
        if (!rst_n) begin
            ph = 0; md = 0; st3 = 0; st5 = 0; sel = 0;
        end else begin
            if (msel_latch_p) sel = msel_cmp;
            if (ph == 0 || ph == 1) begin
                if (!shutdown && (ph == 1 || por_rel_p)) begin
                    st3 = strap_raw[0]; st5 = strap_raw[1];
                    if (rq != 3) md = rq;
                    ph = 2;
                end
            end else if (ph == 2) begin
                ph = shutdown ? 1 : 3;
            end else begin
                if (shutdown) ph = 1;
                else if (rq != 3 && rq != md && (md == 0 || rq == 0)) begin
                    if (md == 0) begin st3 = strap_raw[0]; st5 = strap_raw[1]; end
                    md = rq;
                    ph = 2;
                end
            end
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag, input string nm);
        compared++;
        if (got !== exp) begin
            mism++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, nm, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit live;
        string t;
        live = (ph == 3);
        t = (ph == 0) ? "R1" : (ph == 1) ? "R10" : (ph == 2) ? "R8" : "";
        chk(main_sw_en,  live && md == 0,                                live ? "R3" : t, "main_sw_en");
        chk(d3_sby_en,   live && (md == 1 || (md == 2 && st3 == 0)),     live ? "R3" : t, "d3_sby_en");
        chk(d5_sby_en,   live && md != 0 && st5 == 1,                    live ? "R4" : t, "d5_sby_en");
        chk(mem_lin_en,  live && md == 0 && sel == 0,                    live ? "R5" : t, "mem_lin_en");
        chk(mem_sw_en,   live && md == 0 && sel == 1,                    live ? "R5" : t, "mem_sw_en");
        chk(mem_sby_en,  live && md == 1,                                live ? "R5" : t, "mem_sby_en");
        chk(clk_rail_en, live && md == 0,                                live ? "R6" : t, "clk_rail_en");
        chk(mem_sel_hi,  sel[0],                                         "R7", "mem_sel_hi");
    end

    task automatic go(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic logic all_off();
        return !(main_sw_en | d3_sby_en | d5_sby_en | mem_lin_en | mem_sw_en | mem_sby_en | clk_rail_en);
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        compared++; mism++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        go(3); rst_n = 1'b1;
        go(3); chk(all_off(), 1'b1, "R1", "off before por");
        msel_cmp = 1'b1; msel_latch_p = 1'b1; go(1); msel_latch_p = 1'b0;
        chk(mem_sel_hi, 1'b1, "R7", "select load");
        msel_cmp = 1'b0; go(2); chk(mem_sel_hi, 1'b1, "R7", "select hold");
        por_rel_p = 1'b1; go(1); por_rel_p = 1'b0;
        chk(all_off(), 1'b1, "R8", "gap after por");
        go(1); chk(mem_sw_en, 1'b1, "R5", "3.3V switch"); chk(clk_rail_en, 1'b1, "R6", "clk in run");
        strap_raw = 2'b11; op_req = 2'b01; go(1);
        chk(all_off(), 1'b1, "R8", "gap to STR");
        go(1); chk(d5_sby_en, 1'b1, "R4", "5V kept STR"); chk(mem_sby_en, 1'b1, "R5", "mem STR");
        strap_raw = 2'b00; go(3); chk(d5_sby_en, 1'b1, "R2", "strap ignored asleep");
        op_req = 2'b10; go(3); chk(mem_sby_en, 1'b1, "R9", "STR to off ignored");
        op_req = 2'b11; go(3); chk(mem_sby_en, 1'b1, "R9", "code 11 ignored");
        op_req = 2'b00; go(2); chk(main_sw_en, 1'b1, "R3", "back to run");
        strap_raw = 2'b11; op_req = 2'b10; go(2);
        chk(d3_sby_en, 1'b0, "R3", "3.3V dropped off"); chk(d5_sby_en, 1'b1, "R4", "5V kept off");
        strap_raw = 2'b00; go(3); chk(d3_sby_en, 1'b0, "R2", "strap ignored in off");
        op_req = 2'b00; go(2);
        msel_cmp = 1'b0; msel_latch_p = 1'b1; go(1); msel_latch_p = 1'b0;
        chk(mem_lin_en, 1'b1, "R7", "2.5V driver");
        msel_cmp = 1'b1; go(2); chk(mem_lin_en, 1'b1, "R7", "cmp ignored");
        op_req = 2'b10; go(2);
        chk(d3_sby_en, 1'b1, "R3", "3.3V kept off"); chk(d5_sby_en, 1'b0, "R4", "5V dropped");
        shutdown = 1'b1; go(1); chk(all_off(), 1'b1, "R10", "shutdown off");
        strap_raw = 2'b11; go(3); chk(all_off(), 1'b1, "R10", "held off");
        shutdown = 1'b0; go(1); chk(all_off(), 1'b1, "R10", "gap on release");
        go(1); chk(d3_sby_en, 1'b0, "R10", "recaptured strap3"); chk(d5_sby_en, 1'b1, "R10", "recaptured strap5");
        op_req = 2'b00; go(2);
        shutdown = 1'b1; go(1); chk(all_off(), 1'b1, "R10", "shutdown from run");
        shutdown = 1'b0; go(2); chk(main_sw_en, 1'b1, "R10", "run after release");
        go(5);
        finish_run();
    end

endmodule